// File: doc/BRIEF.md
# Prescaled Timebase Counter

A free-running up-counter that serves as the time reference for a timer subsystem. The system clock reaches the counter through a divider. The divide ratio is a power of two that a 3-bit select chooses. A run bit starts and stops counting. When the count wraps from its all-ones value back to zero, a sticky overflow flag is set, and an interrupt request is raised if it is enabled.

An optional match-reset mode returns the count to zero on the tick after it equals an externally held compare value. This turns the block into a programmable-period timebase. Software clears the flag by writing a one to it. When fast-clear is on, a counter read strobe also clears the flag. The count is presented as one full-width value, so a read can never combine halves from different ticks.

Top module: `tick_base`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the interrupt request is 0, and every control bit is 0 (stopped, select 0, match-reset off, interrupt off, fast-clear off).
- R2: With run set and select value p (0 to 7), the count advances by one every 2^p clock edges. After k edges counted from the edge that writes run=1, the count equals k>>p (match-reset off, no wrap).
- R3: Clearing run freezes the count at its current value for as long as run stays 0.
- R4: The overflow flag is set on the tick that takes the count from all ones to zero, and not before.
- R5: The interrupt request is high exactly when the flag and the interrupt enable are both 1.
- R6: Pulsing the write-one-to-clear input clears the flag.
- R7: A counter read strobe clears the flag only when fast-clear is enabled. With fast-clear off, the flag is kept.
- R8: With match-reset on and compare value C, the tick after the count equals C loads zero. With select 0, after k edges the count is k mod (C+1).
- R9: With match-reset on and compare value 0, the count stays at 0.
- R10: With match-reset on and compare value all ones, the flag is never set.
- R11: The prescale divider restarts from zero when run is cleared or when a write changes the select. The first tick after either event comes a full 2^p edges later.
- R12: If a flag clear and a flag set happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all control fields below on this edge |
| cfg_run | input | 1 | Run enable |
| cfg_psel | input | PS_W | Prescale select, divide by 2^value |
| cfg_match_rst | input | 1 | Enable reset of the count on compare match |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_fast_clr | input | 1 | Allow a counter read to clear the flag |
| cmp_val | input | CNT_W | Compare value used for match-reset |
| cnt_rd | input | 1 | Counter read strobe |
| flag_w1c | input | 1 | Write-one pulse that clears the flag |
| cnt_q | output | CNT_W | Current count, full width |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the counter with CNT_W=8 and keeps PS_W=3, so the full range of prescale codes is present. With an 8-bit count, a wrap takes only 256 ticks. This makes it cheap to reach the overflow edge, the all-ones compare corner and the set-versus-clear collision on the exact wrap edge. The bench sweeps every prescale code with per-cycle checks, and it sweeps a spread of compare values, both with and without prescaling.

// File: rtl/tick_base.sv
module tick_base #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic [PS_W-1:0]  cfg_psel,
  input  logic             cfg_match_rst,
  input  logic             cfg_ovf_ie,
  input  logic             cfg_fast_clr,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_rd,
  input  logic             flag_w1c,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_flag,
  output logic             ovf_irq
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic            run_q, match_q, ie_q, fast_q;
  logic [PS_W-1:0] psel_q;
  logic [DIV_W-1:0] pdiv_q, lim;
  logic tick, hit_rst, ovf_set, ovf_clr, div_restart;

  assign lim         = ~({DIV_W{1'b1}} << psel_q);
  assign tick        = run_q && (pdiv_q == lim);
  assign hit_rst     = match_q && (cnt_q == cmp_val);
  assign ovf_set     = tick && !hit_rst && (cnt_q == CNT_MAX);
  assign ovf_clr     = flag_w1c || (fast_q && cnt_rd);
  assign div_restart = cfg_we && (!cfg_run || (cfg_psel != psel_q));
  assign ovf_irq     = ovf_flag && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      psel_q  <= '0;
      match_q <= 1'b0;
      ie_q    <= 1'b0;
      fast_q  <= 1'b0;
    end else if (cfg_we) begin
      run_q   <= cfg_run;
      psel_q  <= cfg_psel;
      match_q <= cfg_match_rst;
      ie_q    <= cfg_ovf_ie;
      fast_q  <= cfg_fast_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pdiv_q <= '0;
    else if (div_restart) pdiv_q <= '0;
    else if (tick)        pdiv_q <= '0;
    else if (run_q)       pdiv_q <= pdiv_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick)    cnt_q <= hit_rst ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q));

  p_flag_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cnt_q) == CNT_MAX) && (cnt_q == '0));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w1c && cnt_q != CNT_MAX) |=> !ovf_flag);

  p_match_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match_q && cnt_q == cmp_val) |=> (cnt_q == '0));

  p_no_flag_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> !($past(match_q) && $past(cmp_val) == CNT_MAX));

  p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_flag |-> !ovf_irq);
endmodule

// File: tb/tick_base_tb.sv
module tick_base_tb;
  localparam int CW = 8;
  localparam int PW = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_run = 0, cfg_match_rst = 0, cfg_ovf_ie = 0, cfg_fast_clr = 0;
  logic [PW-1:0] cfg_psel = '0;
  logic [CW-1:0] cmp_val = '0;
  logic cnt_rd = 0, flag_w1c = 0;
  logic [CW-1:0] cnt_q;
  logic ovf_flag, ovf_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tick_base #(.CNT_W(CW), .PS_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
    .cfg_psel(cfg_psel), .cfg_match_rst(cfg_match_rst), .cfg_ovf_ie(cfg_ovf_ie),
    .cfg_fast_clr(cfg_fast_clr), .cmp_val(cmp_val), .cnt_rd(cnt_rd),
    .flag_w1c(flag_w1c), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic run, input int ps, input logic mr, input logic ie, input logic fc);
    cfg_run = run; cfg_psel = PW'(ps); cfg_match_rst = mr; cfg_ovf_ie = ie; cfg_fast_clr = fc;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt", int'(cnt_q), 0);
    chk("R1 flag", int'(ovf_flag), 0);
    chk("R1 irq", int'(ovf_irq), 0);
    wait_n(5);
    chk("R1 stopped", int'(cnt_q), 0);

    // R2 every prescale code, per-cycle
    for (int p = 0; p < 8; p++) begin
      do_reset();
      cfg(1, p, 0, 0, 0);
      for (int k = 0; k <= 3 * (1 << p) + 2; k++) begin
        chk($sformatf("R2 p=%0d k=%0d", p, k), int'(cnt_q), k >> p);
        @(negedge clk);
      end
    end

    // R3 freeze, R11 restart after run cleared
    do_reset();
    cfg(1, 2, 0, 0, 0);
    wait_n(10);
    cfg(0, 2, 0, 0, 0);
    for (int k = 0; k < 20; k++) begin
      chk("R3 frozen", int'(cnt_q), 2);
      @(negedge clk);
    end
    cfg(1, 2, 0, 0, 0);
    wait_n(3);
    chk("R11 run restart early", int'(cnt_q), 2);
    wait_n(1);
    chk("R11 run restart tick", int'(cnt_q), 3);

    // R11 select change restarts divider
    do_reset();
    cfg(1, 3, 0, 0, 0);
    wait_n(5);
    cfg(1, 1, 0, 0, 0);
    wait_n(1);
    chk("R11 psel early", int'(cnt_q), 0);
    wait_n(1);
    chk("R11 psel tick", int'(cnt_q), 1);

    // R4 wrap sets flag, R5 irq, R6 w1c
    do_reset();
    cfg(1, 0, 0, 0, 0);
    wait_n(MAXV);
    chk("R4 before wrap cnt", int'(cnt_q), MAXV);
    chk("R4 before wrap flag", int'(ovf_flag), 0);
    wait_n(1);
    chk("R4 wrap cnt", int'(cnt_q), 0);
    chk("R4 wrap flag", int'(ovf_flag), 1);
    chk("R5 irq disabled", int'(ovf_irq), 0);
    cfg(1, 0, 0, 1, 0);
    chk("R5 irq enabled", int'(ovf_irq), 1);
    flag_w1c = 1'b1; @(negedge clk); flag_w1c = 1'b0;
    chk("R6 flag cleared", int'(ovf_flag), 0);
    chk("R5 irq follows", int'(ovf_irq), 0);

    // R7 read strobe with and without fast-clear
    do_reset();
    cfg(1, 0, 0, 0, 0);
    wait_n(MAXV + 1);
    chk("R7 flag up", int'(ovf_flag), 1);
    cnt_rd = 1'b1; @(negedge clk); cnt_rd = 1'b0;
    chk("R7 read no fast", int'(ovf_flag), 1);
    cfg(1, 0, 0, 0, 1);
    chk("R7 still set", int'(ovf_flag), 1);
    cnt_rd = 1'b1; @(negedge clk); cnt_rd = 1'b0;
    chk("R7 read fast", int'(ovf_flag), 0);

    // R12 set beats clear on the wrap edge
    do_reset();
    cfg(1, 0, 0, 0, 0);
    wait_n(MAXV);
    flag_w1c = 1'b1; @(negedge clk); flag_w1c = 1'b0;
    chk("R12 set wins", int'(ovf_flag), 1);

    // R8 match reset sweep, prescale 0
    for (int c = 1; c < MAXV; c += 23) begin
      do_reset();
      cmp_val = CW'(c);
      cfg(1, 0, 1, 0, 0);
      for (int k = 0; k <= 2 * (c + 1) + 1; k++) begin
        chk($sformatf("R8 c=%0d k=%0d", c, k), int'(cnt_q), k % (c + 1));
        @(negedge clk);
      end
      chk("R8 no flag", int'(ovf_flag), 0);
    end

    // R8 match with prescale 2
    do_reset();
    cmp_val = CW'(3);
    cfg(1, 2, 1, 0, 0);
    for (int k = 0; k < 40; k++) begin
      chk("R8 prescaled", int'(cnt_q), (k >> 2) % 4);
      @(negedge clk);
    end

    // R9 compare 0 holds zero
    do_reset();
    cmp_val = '0;
    cfg(1, 0, 1, 0, 0);
    for (int k = 0; k < 50; k++) begin
      chk("R9 stuck zero", int'(cnt_q), 0);
      @(negedge clk);
    end

    // R10 compare all ones, no flag
    do_reset();
    cmp_val = CW'(MAXV);
    cfg(1, 0, 1, 0, 0);
    for (int k = 0; k < 3 * (MAXV + 1); k++) begin
      chk("R10 count", int'(cnt_q), k % (MAXV + 1));
      @(negedge clk);
    end
    chk("R10 flag never", int'(ovf_flag), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule